// File: doc/BRIEF.md
# Clock Domain Profile Sequencer

This block moves one clock domain to a new operating point in a single transaction. A start strobe comes with a requested bus rate in MHz and the current PLL output rate. The block looks the rate up in the domain's profile table. That lookup gives a PLL target and one 8-bit divide value for every divided output of the domain. The block then writes every divider and asks an external PLL sequencer to retune. It picks the order of these two steps at run time, so that no downstream clock ever runs faster than its final rate while the change is in progress.

The default build serves the system domain: 16 dividers and four bus rates. A parameter selects the smaller peripheral domain instead: three dividers and six rates. The PLL sequencer and the dividers themselves lie outside the block.

Top module: `clk_profile_seq`

## Requirements
- R1: In the default build, the accepted request rates are 200, 400, 600 and 800 MHz. Their PLL targets are 800, 800, 600 and 800 MHz. The target is shown on `pll_target_o` for as long as `pll_req_o` is high, and each accepted request raises `pll_req_o` exactly once.
- R2: Each accepted request writes all 16 dividers. The writes come on 16 consecutive cycles in ascending index order. Divider i sits at address 0x180 + 0x10*i.
- R3: Each divide value is 8 bits wide. Divider 1 (the bus divider) is set to target/rate. Every other divider has a nominal value at an 800 MHz PLL: 4 for index 0, 2 for indices 2 to 5, 1 for 6, 2 for 7, 4 for 8, 2 for 9, 4 for 10, 8 for 11, 24 for 12, 4 for 13, 24 for 14 and 16 for 15. A nominal value of 2 or less is written unchanged. A larger nominal value is scaled to nominal*target/800.
- R4: When the target is below `cur_pll_i` at start, `pll_req_o` rises in the cycle after the start. The first divider write comes in the cycle after `pll_done_i` is sampled high.
- R5: When the target is at or above `cur_pll_i`, the first write comes in the cycle after the start. `pll_req_o` rises in the cycle after the last write.
- R6: A rate that matches no profile gives `done_o` and `err_o` together in the cycle after the start. No divider write is made and `pll_req_o` is not raised.
- R7: `pll_req_o` stays high until `pll_done_i` is sampled. If `pll_err_i` is high with that done, the error appears on `err_o` at completion, and the full set of divider writes is still made.
- R8: `done_o` is a one-cycle pulse that comes after both phases. It comes NUM_DIV + L + 1 cycles after the start, where L is the number of cycles the PLL sequencer takes to answer. `err_o` is high only together with `done_o`, and only if an error occurred.
- R9: `busy_o` is high from the cycle after an accepted start until `done_o`. A start that arrives while busy is ignored. Out of reset the block is idle, with every output strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a profile change (taken only while idle) |
| req_rate_i | input | 12 | Requested bus rate in MHz |
| cur_pll_i | input | 12 | Current PLL output rate in MHz |
| div_we_o | output | 1 | Divider write strobe |
| div_addr_o | output | 12 | Divider register address |
| div_data_o | output | 8 | Divide value (0 would stop the output) |
| pll_req_o | output | 1 | PLL retune request, held until answered |
| pll_target_o | output | 12 | PLL target rate in MHz |
| pll_done_i | input | 1 | PLL sequencer finished |
| pll_err_i | input | 1 | PLL sequencer error, valid with done |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction complete pulse |
| err_o | output | 1 | Error indication, valid with done |

## Verification
The start is sampled on one edge, and every result is counted from the cycle after it. A request the table rejects completes one cycle later. The first write comes one cycle after the start when the dividers go first, or one cycle after the PLL answers when the PLL goes first. Completion is due at 16 + L + 1 cycles after the start in both orders. The bench keeps a cycle counter on the falling edge and stamps every write, request edge and done pulse with it. It compares these stamps with the exact cycles due for its own PLL model's latency, which is chosen at random for each transaction.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PLL_PRE  = 2'd1,
        ST_DIV      = 2'd2,
        ST_PLL_POST = 2'd3
    } cps_state_e;

    // Domain 0: system domain, domain 1: peripheral domain
    function automatic int unsigned dom_num_prof(input int dom);
        return (dom == 0) ? 4 : 6;
    endfunction

    function automatic int unsigned dom_num_div(input int dom);
        return (dom == 0) ? 16 : 3;
    endfunction

    function automatic int unsigned dom_base_addr(input int dom);
        return (dom == 0) ? 32'h180 : 32'h380;
    endfunction

    function automatic int unsigned prof_rate(input int dom, input int p);
        return (dom == 0) ? (p + 1) * 200 : (p + 1) * 25;
    endfunction

    function automatic int unsigned prof_pll(input int dom, input int p);
        if (dom == 0) return (p == 2) ? 600 : 800;
        return (p == 4) ? 750 : 600;
    endfunction

    // divide value of the system outputs at an 800 MHz PLL
    function automatic int unsigned sys_nominal(input int d);
        case (d)
            0, 8, 10, 13:  return 4;
            2, 3, 4, 5:    return 2;
            7, 9:          return 2;
            6:             return 1;
            11:            return 8;
            12, 14:        return 24;
            15:            return 16;
            default:       return 1;
        endcase
    endfunction

    function automatic int unsigned prof_div(input int dom, input int p, input int d);
        int unsigned t, r, b;
        t = prof_pll(dom, p);
        r = prof_rate(dom, p);
        if (dom == 0) begin
            if (d == 1) return t / r;
            b = sys_nominal(d);
            if (b <= 2) return b;
            return (b * t) / 800;
        end
        case (d)
            0:       return t / r;
            1:       return t / 150;
            default: return t / 75;
        endcase
    endfunction

endpackage

// File: rtl/cps_lookup.sv
module cps_lookup
    import cps_pkg::*;
#(
    parameter int DOMAIN   = 0,
    parameter int NUM_PROF = 4,
    parameter int RATE_W   = 12,
    parameter int PIDX_W   = 2
) (
    input  logic [RATE_W-1:0] req_rate_i,
    output logic              hit_o,
    output logic [PIDX_W-1:0] idx_o,
    output logic [RATE_W-1:0] tgt_o
);
    logic [NUM_PROF-1:0] match;
    logic [RATE_W-1:0]   tgt_tab [NUM_PROF];

    for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
        localparam logic [RATE_W-1:0] RATE_P = RATE_W'(prof_rate(DOMAIN, p));
        assign match[p]   = (req_rate_i == RATE_P);
        assign tgt_tab[p] = RATE_W'(prof_pll(DOMAIN, p));
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        tgt_o = '0;
        for (int p = NUM_PROF - 1; p >= 0; p--) begin
            if (match[p]) begin
                hit_o = 1'b1;
                idx_o = PIDX_W'(p);
                tgt_o = tgt_tab[p];
            end
        end
    end
endmodule

// File: rtl/cps_div_table.sv
module cps_div_table
    import cps_pkg::*;
#(
    parameter int DOMAIN   = 0,
    parameter int NUM_PROF = 4,
    parameter int NUM_DIV  = 16,
    parameter int PIDX_W   = 2,
    parameter int DIDX_W   = 4,
    parameter int ADDR_W   = 12,
    parameter int DIV_W    = 8
) (
    input  logic [PIDX_W-1:0] prof_i,
    input  logic [DIDX_W-1:0] div_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DIV_W-1:0]  data_o
);
    localparam int unsigned BASE   = dom_base_addr(DOMAIN);
    localparam int unsigned STRIDE = 16;

    logic [DIV_W-1:0]  val_tab  [NUM_PROF][NUM_DIV];
    logic [ADDR_W-1:0] addr_tab [NUM_DIV];

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        assign addr_tab[d] = ADDR_W'(BASE + STRIDE * d);
        for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
            assign val_tab[p][d] = DIV_W'(prof_div(DOMAIN, p, d));
        end
    end

    always_comb begin
        addr_o = '0;
        data_o = '0;
        if (int'(div_i) < NUM_DIV && int'(prof_i) < NUM_PROF) begin
            addr_o = addr_tab[div_i];
            data_o = val_tab[prof_i][div_i];
        end
    end
endmodule

// File: rtl/clk_profile_seq.sv
module clk_profile_seq
    import cps_pkg::*;
#(
    parameter int DOMAIN = 0,
    parameter int RATE_W = 12,
    parameter int ADDR_W = 12,
    parameter int DIV_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [RATE_W-1:0] req_rate_i,
    input  logic [RATE_W-1:0] cur_pll_i,
    output logic              div_we_o,
    output logic [ADDR_W-1:0] div_addr_o,
    output logic [DIV_W-1:0]  div_data_o,
    output logic              pll_req_o,
    output logic [RATE_W-1:0] pll_target_o,
    input  logic              pll_done_i,
    input  logic              pll_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int NUM_PROF = dom_num_prof(DOMAIN);
    localparam int NUM_DIV  = dom_num_div(DOMAIN);
    localparam int PIDX_W   = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;
    localparam int DIDX_W   = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;
    localparam logic [DIDX_W-1:0] LAST_DIV = DIDX_W'(NUM_DIV - 1);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(16);

    typedef struct packed {
        cps_state_e        st;
        logic [PIDX_W-1:0] prof;
        logic [DIDX_W-1:0] cnt;
        logic [RATE_W-1:0] tgt;
        logic              pll_first;
        logic              err_acc;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              lk_hit;
    logic [PIDX_W-1:0] lk_idx;
    logic [RATE_W-1:0] lk_tgt;

    cps_lookup #(
        .DOMAIN(DOMAIN), .NUM_PROF(NUM_PROF), .RATE_W(RATE_W), .PIDX_W(PIDX_W)
    ) u_lookup (
        .req_rate_i(req_rate_i),
        .hit_o     (lk_hit),
        .idx_o     (lk_idx),
        .tgt_o     (lk_tgt)
    );

    cps_div_table #(
        .DOMAIN(DOMAIN), .NUM_PROF(NUM_PROF), .NUM_DIV(NUM_DIV),
        .PIDX_W(PIDX_W), .DIDX_W(DIDX_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)
    ) u_table (
        .prof_i(seq_q.prof),
        .div_i (seq_q.cnt),
        .addr_o(div_addr_o),
        .data_o(div_data_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!lk_hit) begin
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                    end else begin
                        seq_d.prof      = lk_idx;
                        seq_d.tgt       = lk_tgt;
                        seq_d.cnt       = '0;
                        seq_d.err_acc   = 1'b0;
                        seq_d.pll_first = (lk_tgt < cur_pll_i);
                        seq_d.st        = (lk_tgt < cur_pll_i) ? ST_PLL_PRE : ST_DIV;
                    end
                end
            end
            ST_PLL_PRE: begin
                if (pll_done_i) begin
                    seq_d.err_acc = pll_err_i;
                    seq_d.cnt     = '0;
                    seq_d.st      = ST_DIV;
                end
            end
            ST_DIV: begin
                if (seq_q.cnt == LAST_DIV) begin
                    if (seq_q.pll_first) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.err  = seq_q.err_acc;
                    end else begin
                        seq_d.st = ST_PLL_POST;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + DIDX_W'(1);
                end
            end
            ST_PLL_POST: begin
                if (pll_done_i) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                    seq_d.err  = seq_q.err_acc | pll_err_i;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{st: ST_IDLE, default: '0};
        else         seq_q <= seq_d;
    end

    assign div_we_o     = (seq_q.st == ST_DIV);
    assign pll_req_o    = (seq_q.st == ST_PLL_PRE) || (seq_q.st == ST_PLL_POST);
    assign pll_target_o = seq_q.tgt;
    assign busy_o       = (seq_q.st != ST_IDLE);
    assign done_o       = seq_q.done;
    assign err_o        = seq_q.err;

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(div_we_o && pll_req_o));                                            // R4
    AST_ADDR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_we_o && $past(div_we_o)) |-> (div_addr_o == $past(div_addr_o) + ADDR_STEP)); // R2
    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_req_o && !pll_done_i) |=> pll_req_o);                            // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> done_o);                                                    // R8
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!div_we_o && !pll_req_o));                               // R9
    AST_TARGET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_req_o && $past(pll_req_o)) |-> $stable(pll_target_o));           // R1
    AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_we_o |-> (div_data_o != '0));                                     // R3
endmodule

// File: tb/tb_clk_profile_seq.sv
module tb_clk_profile_seq;
    localparam int ND = 16;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] req_rate_i = '0;
    logic [11:0] cur_pll_i = 12'd800;
    logic        div_we_o, pll_req_o, busy_o, done_o, err_o;
    logic [11:0] div_addr_o, pll_target_o;
    logic [7:0]  div_data_o;
    logic        pll_done_i = 1'b0;
    logic        pll_err_i = 1'b0;

    clk_profile_seq dut (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .req_rate_i(req_rate_i),
        .cur_pll_i(cur_pll_i), .div_we_o(div_we_o), .div_addr_o(div_addr_o),
        .div_data_o(div_data_o), .pll_req_o(pll_req_o), .pll_target_o(pll_target_o),
        .pll_done_i(pll_done_i), .pll_err_i(pll_err_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit finished = 0;

    int wr_addr [32], wr_data [32], wr_cyc [32];
    int n_wr, n_req, req_first, req_tgt, n_done, done_cyc;
    bit done_err, req_prev;
    int pll_lat = 1, pcnt = 0;
    bit pll_err_mode = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input int rate);
        case (rate)
            200: return 0;
            400: return 1;
            600: return 2;
            800: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int exp_tgt(input int i);
        return (i == 2) ? 600 : 800;
    endfunction

    function automatic int exp_nom(input int d);
        int tab [16] = '{4, 0, 2, 2, 2, 2, 1, 2, 4, 2, 4, 8, 24, 4, 24, 16};
        return tab[d];
    endfunction

    function automatic int exp_div(input int i, input int d);
        int t, n;
        t = exp_tgt(i);
        if (d == 1) return t / ((i + 1) * 200);
        n = exp_nom(d);
        return (n <= 2) ? n : n * t / 800;
    endfunction

    // monitor and PLL sequencer model, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (div_we_o) begin
            if (n_wr < 32) begin
                wr_addr[n_wr] = int'(div_addr_o);
                wr_data[n_wr] = int'(div_data_o);
                wr_cyc[n_wr]  = cyc;
            end
            n_wr++;
        end
        if (pll_req_o && !req_prev) begin
            n_req++;
            req_first = cyc;
            req_tgt   = int'(pll_target_o);
        end
        req_prev = pll_req_o;
        if (done_o) begin
            n_done++;
            done_cyc = cyc;
            done_err = err_o;
        end
        if (pll_done_i) begin
            pll_done_i = 1'b0;
            pll_err_i  = 1'b0;
            pcnt       = 0;
        end else if (pll_req_o) begin
            pcnt++;
            if (pcnt >= pll_lat) begin
                pll_done_i = 1'b1;
                pll_err_i  = pll_err_mode;
                cur_pll_i  = pll_target_o;
            end
        end
    end

    task automatic clear_log();
        n_wr = 0; n_req = 0; n_done = 0; req_first = 0; req_tgt = 0;
        done_cyc = 0; done_err = 0;
    endtask

    task automatic wait_done(input int limit);
        int g = 0;
        while (n_done == 0 && g < limit) begin
            @(negedge clk); #1;
            g++;
        end
        chk(n_done != 0, "R8 done reached", n_done, 1);
    endtask

    task automatic run_txn(input int rate, input int lat, input bit perr);
        int cs, idx, t, cur0, bad;
        bit pf;
        @(negedge clk); #1;
        clear_log();
        pll_lat = lat; pll_err_mode = perr;
        cur0 = int'(cur_pll_i);
        start_i = 1'b1; req_rate_i = 12'(rate);
        cs = cyc;
        @(negedge clk); #1;
        start_i = 1'b0;
        wait_done(200);
        repeat (2) @(negedge clk);
        #1;
        idx = exp_idx(rate);
        if (idx < 0) begin
            chk(n_wr == 0 && n_req == 0, "R6 no write or request", n_wr + n_req, 0);
            chk(done_cyc == cs + 1, "R6 reject done cycle", done_cyc - cs, 1);
            chk(done_err == 1'b1, "R6 reject error", done_err, 1);
            return;
        end
        t  = exp_tgt(idx);
        pf = (t < cur0);
        chk(n_wr == ND, "R2 write count", n_wr, ND);
        bad = -1;
        for (int k = 0; k < ND && k < n_wr; k++)
            if (wr_addr[k] != 'h180 + 16 * k || wr_cyc[k] != wr_cyc[0] + k) bad = k;
        chk(bad < 0, "R2 address order", (bad < 0) ? 0 : wr_addr[bad], (bad < 0) ? 0 : 'h180 + 16 * bad);
        bad = -1;
        for (int k = 0; k < ND && k < n_wr; k++)
            if (wr_data[k] != exp_div(idx, k)) bad = k;
        chk(bad < 0, "R3 divide values", (bad < 0) ? 0 : wr_data[bad], (bad < 0) ? 0 : exp_div(idx, bad));
        chk(n_req == 1 && req_tgt == t, "R1 PLL target", req_tgt, t);
        if (pf) begin
            chk(req_first == cs + 1, "R4 PLL request first", req_first - cs, 1);
            chk(wr_cyc[0] == cs + lat + 1, "R4 writes after PLL", wr_cyc[0] - cs, lat + 1);
        end else begin
            chk(wr_cyc[0] == cs + 1, "R5 writes first", wr_cyc[0] - cs, 1);
            chk(req_first == cs + ND + 1, "R5 PLL after writes", req_first - cs, ND + 1);
        end
        chk(n_done == 1 && done_cyc == cs + lat + ND + 1, "R8 done cycle", done_cyc - cs, lat + ND + 1);
        chk(done_err == perr, "R7 error passthrough", done_err, perr);
    endtask

    initial begin
        int seed, r;
        seed = 1234;
        r = $urandom(seed);
        clear_log();
        repeat (4) @(negedge clk);
        #1;
        chk(!busy_o && !done_o && !div_we_o && !pll_req_o && !err_o, "R9 reset state",
            {busy_o, done_o, div_we_o, pll_req_o, err_o}, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!busy_o && n_wr == 0, "R9 idle after reset", busy_o, 0);

        run_txn(600, 2, 0);   // target drops 800 -> 600: PLL first (R4)
        run_txn(200, 3, 0);   // target rises 600 -> 800: writes first (R5)
        run_txn(400, 1, 0);   // equal target: writes first (R5)
        run_txn(500, 1, 0);   // no such profile (R6)
        run_txn(600, 4, 1);   // PLL error with PLL first (R7)
        run_txn(800, 2, 1);   // PLL error with writes first (R7)

        // start while busy is ignored (R9)
        @(negedge clk); #1;
        clear_log();
        pll_lat = 2; pll_err_mode = 0;
        start_i = 1'b1; req_rate_i = 12'd400;
        @(negedge clk); #1;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(busy_o == 1'b1, "R9 busy during transaction", busy_o, 1);
        start_i = 1'b1; req_rate_i = 12'd600;
        @(negedge clk); #1;
        start_i = 1'b0;
        wait_done(200);
        repeat (30) @(negedge clk);
        #1;
        chk(n_done == 1 && n_wr == ND, "R9 start while busy ignored", n_done * 100 + n_wr, 100 + ND);
        chk(wr_data[1] == 2 && busy_o == 1'b0, "R9 first request kept", wr_data[1], 2);

        for (int i = 0; i < 40; i++) begin
            int k, rate;
            k = $urandom % 5;
            rate = (k < 4) ? (k + 1) * 200 : 100 + 200 * ($urandom % 4);
            run_txn(rate, 1 + ($urandom % 6), ($urandom % 8) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule